// File: doc/BRIEF.md
# Floating-Point Control Register and Issue-Time Mode Checker

This block keeps the floating-point control and status word of a core and vets every floating-point operation just before it issues. The word carries five sticky exception flags, a three-bit dynamic rounding mode and a two-bit accuracy mode. For each operation it receives the instruction's rounding field and an operation-class code. It then returns the rounding mode to use, the accuracy mode to use, and an illegal-instruction trap request. Mode 00 selects strict IEEE behaviour.

A CSR port reads and writes the word through three views: the whole word, the rounding field alone, or the flags alone. Execution units report completed operations on a flag-merge input, and those flags are ORed into the sticky flags. Which accuracy modes each operation class accepts is fixed by a support-map parameter, four bits per class. Software may store any accuracy mode without a fault. A trap happens only when an operation issues under a combination the map does not support.

Top module: `fpc_unit`

## Requirements
- R1: After reset the whole word reads as zero: flags 0, rounding mode 000, accuracy mode 00.
- R2: With `csr_view` = 2'b00 (whole word) a read returns flags at bits [4:0], rounding mode at [7:5], accuracy mode at [9:8] and zero in [31:10]. A write loads those three fields from the same positions and ignores bits [31:10].
- R3: View 2'b01 reads the rounding mode at bits [2:0] and a write changes only that field, from `csr_wdata[2:0]`. View 2'b10 does the same for the flags at [4:0]. View 2'b11 reads zero and ignores writes. All other read bits are zero.
- R4: When `op_rm` is not 3'b111, `eff_rm` equals `op_rm`.
- R5: When `op_rm` is 3'b111, `eff_rm` equals the stored rounding mode. If the stored value is 3'b101, 3'b110 or 3'b111, a valid operation raises `op_trap`.
- R6: A valid operation of class c under stored accuracy mode m raises `op_trap` when bit 4*c+m of `SUPPORT_MAP` is 0, for m other than 00.
- R7: Accuracy mode 00 is accepted for every class, even when the map clears its bit.
- R8: Writing any accuracy mode never raises `op_trap` by itself. `op_trap` is low whenever `op_valid` is low.
- R9: In a cycle with `cmp_valid` high and no CSR write that covers the flags, `cmp_flags` is ORed into the stored flags. Flags are never cleared except by such a write.
- R10: A CSR write through view 2'b00 or 2'b10 replaces the flags and discards a same-cycle `cmp_flags` merge. A write through view 2'b01 lets the merge proceed.
- R11: `eff_acc` always equals the stored accuracy mode, which changes only on a whole-word write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | CSR access strobe |
| csr_we | input | 1 | CSR write enable (with `csr_en`) |
| csr_view | input | 2 | Access view: 00 word, 01 rounding, 10 flags, 11 none |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for the selected view (combinational) |
| op_valid | input | 1 | Operation presented for issue |
| op_rm | input | 3 | Instruction rounding field; 111 selects the stored mode |
| op_class | input | CLS_W | Operation class code |
| eff_rm | output | 3 | Rounding mode to use |
| eff_acc | output | 2 | Accuracy mode to use |
| op_trap | output | 1 | Illegal-instruction trap request |
| cmp_valid | input | 1 | Completion with exception flags |
| cmp_flags | input | 5 | Exception flags of the completing operation |

## Verification
The in-RTL properties assume that reset is held for at least one clock edge. They also assume that `op_class` and `op_rm` are stable across the evaluation window of a cycle, because the trap and mode outputs are combinational. The flag-stickiness property assumes that only a flag-covering CSR write may clear bits. The bench drives every input once per cycle, at the falling edge, from a fixed-seed random source, so these assumptions hold by construction of the stimulus. Valid operations are biased toward the dynamic rounding selector, so the reserved stored modes are hit often.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int XLEN   = 32;
  localparam int FLAG_W = 5;
  localparam int RM_W   = 3;
  localparam int ACC_W  = 2;
  localparam int NUM_ACC = 1 << ACC_W;
  localparam int USED_W = FLAG_W + RM_W + ACC_W;

  typedef logic [FLAG_W-1:0] flags_t;
  typedef logic [RM_W-1:0]   rm_t;
  typedef logic [ACC_W-1:0]  acc_t;

  typedef enum logic [1:0] {
    VIEW_WORD  = 2'b00,
    VIEW_RM    = 2'b01,
    VIEW_FLAGS = 2'b10,
    VIEW_NONE  = 2'b11
  } csr_view_e;

  localparam rm_t RM_DYN = 3'b111;

  // stored rounding values 101..111 may not be used dynamically
  function automatic logic rm_reserved(input rm_t rm);
    return rm >= 3'b101;
  endfunction

  function automatic logic [XLEN-1:0] pack_word(input flags_t f, input rm_t r, input acc_t a);
    logic [XLEN-1:0] w;
    w = '0;
    w[FLAG_W-1:0] = f;
    w[FLAG_W+RM_W-1:FLAG_W] = r;
    w[USED_W-1:FLAG_W+RM_W] = a;
    return w;
  endfunction
endpackage

// File: rtl/fpc_support_table.sv
module fpc_support_table #(
  parameter int NUM_CLASSES = 4,
  parameter logic [4*NUM_CLASSES-1:0] SUPPORT_MAP = '1,
  localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int PAD_CLASSES = 1 << CLS_W
) (
  output logic [PAD_CLASSES*fpc_pkg::NUM_ACC-1:0] sup_vec
);
  import fpc_pkg::*;

  for (genvar c = 0; c < PAD_CLASSES; c++) begin : g_cls
    if (c < NUM_CLASSES) begin : g_real
      // mode 00 always accepted
      assign sup_vec[c*NUM_ACC] = 1'b1;
      assign sup_vec[c*NUM_ACC+NUM_ACC-1 -: NUM_ACC-1] =
        SUPPORT_MAP[c*NUM_ACC+NUM_ACC-1 -: NUM_ACC-1];
    end else begin : g_pad
      // nonexistent class codes support nothing
      assign sup_vec[c*NUM_ACC +: NUM_ACC] = '0;
    end
  end
endmodule

// File: rtl/fpc_csr_store.sv
module fpc_csr_store
  import fpc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_en,
  input  logic            csr_we,
  input  logic [1:0]      csr_view,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            cmp_valid,
  input  flags_t          cmp_flags,
  output flags_t          cur_flags,
  output rm_t             cur_rm,
  output acc_t            cur_acc
);
  csr_view_e view;
  logic wr_any, wr_word, wr_rmv, wr_flagv;
  logic flag_load, rm_load, acc_load, flag_merge;
  flags_t flags_next;
  rm_t    rm_next;

  assign view     = csr_view_e'(csr_view);
  assign wr_any   = csr_en & csr_we;
  assign wr_word  = wr_any & (view == VIEW_WORD);
  assign wr_rmv   = wr_any & (view == VIEW_RM);
  assign wr_flagv = wr_any & (view == VIEW_FLAGS);

  assign flag_load  = wr_word | wr_flagv;
  assign rm_load    = wr_word | wr_rmv;
  assign acc_load   = wr_word;
  assign flag_merge = cmp_valid & ~flag_load;

  always_comb begin
    flags_next = csr_wdata[FLAG_W-1:0];
    rm_next    = wr_word ? csr_wdata[FLAG_W+RM_W-1:FLAG_W] : csr_wdata[RM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_flags <= '0;
      cur_rm    <= '0;
      cur_acc   <= '0;
    end else begin
      if (flag_load)       cur_flags <= flags_next;
      else if (flag_merge) cur_flags <= cur_flags | cmp_flags;
      if (rm_load)  cur_rm  <= rm_next;
      if (acc_load) cur_acc <= csr_wdata[USED_W-1:FLAG_W+RM_W];
    end
  end

  always_comb begin
    csr_rdata = '0;
    unique case (view)
      VIEW_WORD:  csr_rdata = pack_word(cur_flags, cur_rm, cur_acc);
      VIEW_RM:    csr_rdata[RM_W-1:0] = cur_rm;
      VIEW_FLAGS: csr_rdata[FLAG_W-1:0] = cur_flags;
      VIEW_NONE:  csr_rdata = '0;
      default:    csr_rdata = '0;
    endcase
  end

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_load |=> ((cur_flags & $past(cur_flags)) == $past(cur_flags)));
  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load && cmp_valid) |=> (cur_flags == $past(csr_wdata[FLAG_W-1:0])));
  // R11
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_load |=> $stable(cur_acc));
endmodule

// File: rtl/fpc_op_check.sv
module fpc_op_check
  import fpc_pkg::*;
#(
  parameter int CLS_W = 2,
  localparam int PAD_CLASSES = 1 << CLS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  rm_t              op_rm,
  input  logic [CLS_W-1:0] op_class,
  input  rm_t              cur_rm,
  input  acc_t             cur_acc,
  input  logic [PAD_CLASSES*NUM_ACC-1:0] sup_vec,
  output rm_t              eff_rm,
  output acc_t             eff_acc,
  output logic             op_trap
);
  logic dyn_sel, dyn_bad, acc_ok, acc_bad;
  logic [CLS_W+ACC_W-1:0] sup_idx;

  assign dyn_sel = (op_rm == RM_DYN);
  assign dyn_bad = dyn_sel & rm_reserved(cur_rm);
  assign sup_idx = {op_class, cur_acc};
  assign acc_ok  = sup_vec[sup_idx];
  assign acc_bad = ~acc_ok;

  assign op_trap = op_valid & (dyn_bad | acc_bad);
  assign eff_rm  = dyn_sel ? cur_rm : op_rm;
  assign eff_acc = cur_acc;

  // R5
  dyn_reserved_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_rm == RM_DYN && cur_rm >= 3'b101) |-> op_trap);
  // R7
  ieee_mode_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cur_acc == 2'b00 && op_rm != RM_DYN) |-> !op_trap);
  // R8
  idle_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !op_trap);
  // R4
  static_rm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_rm != RM_DYN) |-> (eff_rm == op_rm));
endmodule

// File: rtl/fpc_unit.sv
module fpc_unit
  import fpc_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter logic [4*NUM_CLASSES-1:0] SUPPORT_MAP = 16'h235F,
  localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int PAD_CLASSES = 1 << CLS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_en,
  input  logic             csr_we,
  input  logic [1:0]       csr_view,
  input  logic [31:0]      csr_wdata,
  output logic [31:0]      csr_rdata,
  input  logic             op_valid,
  input  logic [2:0]       op_rm,
  input  logic [CLS_W-1:0] op_class,
  output logic [2:0]       eff_rm,
  output logic [1:0]       eff_acc,
  output logic             op_trap,
  input  logic             cmp_valid,
  input  logic [4:0]       cmp_flags
);
  flags_t cur_flags;
  rm_t    cur_rm;
  acc_t   cur_acc;
  logic [PAD_CLASSES*NUM_ACC-1:0] sup_vec;

  fpc_support_table #(
    .NUM_CLASSES(NUM_CLASSES),
    .SUPPORT_MAP(SUPPORT_MAP)
  ) u_table (
    .sup_vec(sup_vec)
  );

  fpc_csr_store u_store (
    .clk(clk), .rst_n(rst_n),
    .csr_en(csr_en), .csr_we(csr_we), .csr_view(csr_view),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .cmp_valid(cmp_valid), .cmp_flags(cmp_flags),
    .cur_flags(cur_flags), .cur_rm(cur_rm), .cur_acc(cur_acc)
  );

  fpc_op_check #(.CLS_W(CLS_W)) u_check (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_rm(op_rm), .op_class(op_class),
    .cur_rm(cur_rm), .cur_acc(cur_acc), .sup_vec(sup_vec),
    .eff_rm(eff_rm), .eff_acc(eff_acc), .op_trap(op_trap)
  );
endmodule

// File: tb/fpc_unit_tb_top.sv
`timescale 1ns/100ps
module fpc_unit_tb_top;
  localparam logic [15:0] MAP = 16'h235F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_en = 0, csr_we = 0;
  logic [1:0] csr_view = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic op_valid = 0;
  logic [2:0] op_rm = 0, eff_rm;
  logic [1:0] op_class = 0, eff_acc;
  logic op_trap;
  logic cmp_valid = 0;
  logic [4:0] cmp_flags = 0;

  int total = 0, bad = 0;
  bit done = 0;
  logic [4:0] m_flags = 0;
  logic [2:0] m_rm = 0;
  logic [1:0] m_acc = 0;

  always #2.5 clk = ~clk;

  fpc_unit #(.NUM_CLASSES(4), .SUPPORT_MAP(MAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
    .csr_view(csr_view), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .op_valid(op_valid), .op_rm(op_rm), .op_class(op_class),
    .eff_rm(eff_rm), .eff_acc(eff_acc), .op_trap(op_trap),
    .cmp_valid(cmp_valid), .cmp_flags(cmp_flags)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] v);
    case (v)
      2'b00:   return {22'd0, m_acc, m_rm, m_flags};
      2'b01:   return {29'd0, m_rm};
      2'b10:   return {27'd0, m_flags};
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit exp_trap(input logic [2:0] rm, input logic [1:0] cls);
    bit dynbad, sup;
    dynbad = (rm == 3'b111) && (m_rm >= 3'b101);
    sup = (m_acc == 2'b00) || MAP[cls*4 + m_acc];
    return dynbad || !sup;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit c_en, input bit c_we, input logic [1:0] c_view,
                      input logic [31:0] c_wd, input bit o_v, input logic [2:0] o_rm,
                      input logic [1:0] o_cls, input bit k_v, input logic [4:0] k_f,
                      input string rtag);
    bit t;
    @(negedge clk);
    csr_en = c_en; csr_we = c_we; csr_view = c_view; csr_wdata = c_wd;
    op_valid = o_v; op_rm = o_rm; op_class = o_cls;
    cmp_valid = k_v; cmp_flags = k_f;
    #1;
    chk(csr_rdata == exp_read(c_view), rtag, csr_rdata, exp_read(c_view));
    chk(eff_acc == m_acc, "R11 eff_acc", {30'd0, eff_acc}, {30'd0, m_acc});
    if (!o_v) begin
      chk(op_trap == 1'b0, "R8 idle trap", {31'd0, op_trap}, 32'd0);
    end else begin
      t = exp_trap(o_rm, o_cls);
      if ((o_rm == 3'b111) && (m_rm >= 3'b101))
        chk(op_trap == t, "R5 dyn trap", {31'd0, op_trap}, {31'd0, t});
      else if (m_acc == 2'b00)
        chk(op_trap == t, "R7 ieee trap", {31'd0, op_trap}, {31'd0, t});
      else
        chk(op_trap == t, "R6 map trap", {31'd0, op_trap}, {31'd0, t});
      if (!t) begin
        if (o_rm == 3'b111)
          chk(eff_rm == m_rm, "R5 eff_rm dyn", {29'd0, eff_rm}, {29'd0, m_rm});
        else
          chk(eff_rm == o_rm, "R4 eff_rm static", {29'd0, eff_rm}, {29'd0, o_rm});
      end
    end
    @(posedge clk);
    if (c_en && c_we && (c_view == 2'b00 || c_view == 2'b10)) m_flags = c_wd[4:0];
    else if (k_v) m_flags = m_flags | k_f;
    if (c_en && c_we && c_view == 2'b00) begin m_rm = c_wd[7:5]; m_acc = c_wd[9:8]; end
    if (c_en && c_we && c_view == 2'b01) m_rm = c_wd[2:0];
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset word
    step(1, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R1 reset word");
    // R2 reserved bits ignored
    step(1, 1, 2'b00, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R2 write");
    step(1, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R2 reserved zero");
    // R3 views
    step(1, 1, 2'b01, 32'hFFFF_FFF2, 0, 0, 0, 0, 0, "R3 rm view");
    step(1, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R3 rm only");
    step(1, 1, 2'b11, 32'h0, 0, 0, 0, 0, 0, "R3 none view");
    step(1, 1, 2'b10, 32'h0, 0, 0, 0, 0, 0, "R3 flag view");
    step(1, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R3 flags only");
    // R7 class 3 with map bit0 clear, mode 00
    step(1, 1, 2'b00, 32'h0000_0000, 0, 0, 0, 0, 0, "R2 clear");
    step(0, 0, 2'b00, 0, 1, 3'b001, 2'd3, 0, 0, "R7 forced ieee");
    // R8 unsupported mode written, no op
    step(1, 1, 2'b00, 32'h0000_0300, 0, 0, 0, 0, 0, "R8 write mode3");
    step(0, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R8 no fault");
    step(0, 0, 2'b00, 0, 1, 3'b000, 2'd2, 0, 0, "R6 mode3 cls2");
    // R5 reserved dynamic
    step(1, 1, 2'b00, 32'h0000_00C0, 0, 0, 0, 0, 0, "R5 set rm110");
    step(0, 0, 2'b00, 0, 1, 3'b111, 2'd0, 0, 0, "R5 dyn use");
    // R9 merge and R10 priority
    step(0, 0, 2'b10, 0, 0, 0, 0, 1, 5'b00010, "R9 merge a");
    step(0, 0, 2'b10, 0, 0, 0, 0, 1, 5'b01000, "R9 merge b");
    step(1, 0, 2'b10, 0, 0, 0, 0, 0, 0, "R9 sticky read");
    step(1, 1, 2'b10, 32'h1, 0, 0, 0, 1, 5'b10000, "R10 write wins");
    step(1, 1, 2'b01, 32'h3, 0, 0, 0, 1, 5'b00100, "R10 rm write merge");
    step(1, 0, 2'b10, 0, 0, 0, 0, 0, 0, "R10 flags after");
    for (int i = 0; i < 4000; i++) begin
      bit ce, cw, ov, kv;
      logic [1:0] vw;
      logic [2:0] orm;
      ce = ($urandom % 4) == 0;
      cw = $urandom % 2;
      vw = 2'($urandom);
      ov = ($urandom % 4) != 0;
      orm = ($urandom % 2) ? 3'b111 : 3'($urandom);
      kv = $urandom % 2;
      step(ce, cw, vw, $urandom, ov, orm, 2'($urandom), kv, 5'($urandom),
           (vw == 2'b00) ? "R2 rand read" : "R3 rand read");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule